// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This unit sits between six external interrupt pins and an interrupt controller. Each pin first passes through a two-flop synchroniser. It then goes to a detector whose trigger mode software selects: off, rising edge, falling edge, either edge, high level or low level. A detected event sets a per-pin pending flag. The flag stays set until software clears it. The unit raises a request line toward the controller whenever a pin's pending flag and its enable bit are both set.

Software reaches the unit through a small word-addressed register bus with a combinational read path. There are four word registers: trigger configuration, synchronised pin levels, pending flags and enables. Software programs them in a fixed order. It sets the trigger mode first, then clears any stale pending flag, then sets the enable bit. Low-level triggering is the usual choice for a pin.

Top module: `xirq_trigger_top`

## Requirements
- R1: Each pin goes through two synchroniser flops. A level change is visible in the pin-level register two clock edges after it is driven, and it can set a pending flag on the third edge.
- R2: The configuration register is at byte offset 0x0. Pin i takes its 3-bit trigger code from bits [4i+2:4i]. Bits 4i+3 and bits [31:24] read as zero, and writes to them are discarded.
- R3: Trigger codes 0, 4 and 7 never set a pending flag.
- R4: Code 1 sets the pending flag on a rising edge, code 2 on a falling edge, and code 3 on either edge.
- R5: Code 5 sets the pending flag on every cycle the synchronised pin is high, and code 6 on every cycle it is low. The flag stays set after the level goes away.
- R6: The pending register is at 0x8, with bits [5:0] holding one flag per pin. Writing 0 to a bit clears it and writing 1 leaves it unchanged. A detection in the same cycle as a clear wins.
- R7: In edge modes, a pending flag stays set, with no further edges, until software clears it.
- R8: The enable register is at 0xC. Bits [5:0] can be read and written, and the upper bits read as zero. The enable register changes only when it is written.
- R9: Request i is high exactly when pending bit i and enable bit i are both set. It follows a register change on the same edge.
- R10: Reset clears configuration, pending and enable, and all requests go low.
- R11: The register at 0x4 returns the synchronised pin levels in bits [5:0]. Writes to it have no effect.
- R12: An access whose address bits [1:0] are not zero is ignored. It changes no register and reads back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 6 | Asynchronous external interrupt pins |
| bus_wr_i | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr_i | input | 4 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 6 | Per-pin interrupt request to the controller |

## Verification
The embedded assertions check four things on every cycle. A pending flag can rise only in the cycle after its detector fired. A flag can fall only after a pending write that carried a 0 in its bit. The enable register changes only when it is written. A misaligned write leaves the enables untouched. Only the bench's scenarios can show the rest. These are which edge or level each trigger code actually selects, the exact two- and three-edge latency through the synchroniser, a detection winning over a simultaneous clear, the reserved configuration bits, and the request gating seen at the pins.

// File: rtl/xtu_pkg.sv
`timescale 1ns/1ps
package xtu_pkg;

    typedef enum logic [2:0] {
        TRIG_OFF  = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_BOTH = 3'd3,
        TRIG_HIGH = 3'd5,
        TRIG_LOW  = 3'd6
    } trig_e;

    // Word select values (byte address bits [3:2])
    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_LVL  = 2'd1;
    localparam logic [1:0] SEL_PEND = 2'd2;
    localparam logic [1:0] SEL_EN   = 2'd3;

endpackage

// File: rtl/xtu_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser plus one history stage for edge detection.
module xtu_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/xtu_detect.sv
`timescale 1ns/1ps
// Per-pin trigger decoder: turns synchronised samples into a one-cycle hit.
module xtu_detect
    import xtu_pkg::*;
#(
    parameter int N  = 6,
    parameter int CW = 3
) (
    input  logic [N-1:0][CW-1:0] mode_i,
    input  logic [N-1:0]         cur_i,
    input  logic [N-1:0]         prev_i,
    output logic [N-1:0]         hit_o
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic rise_w, fall_w, h;
        assign rise_w = cur_i[g] & ~prev_i[g];
        assign fall_w = ~cur_i[g] & prev_i[g];

        always_comb begin
            case (mode_i[g])
                TRIG_RISE: h = rise_w;
                TRIG_FALL: h = fall_w;
                TRIG_BOTH: h = rise_w | fall_w;
                TRIG_HIGH: h = cur_i[g];
                TRIG_LOW:  h = ~cur_i[g];
                default:   h = 1'b0;   // off and the spare codes
            endcase
        end

        assign hit_o[g] = h;
    end

endmodule

// File: rtl/xtu_regs.sv
`timescale 1ns/1ps
// Configuration, pending and enable registers with the read mux.
module xtu_regs
    import xtu_pkg::*;
#(
    parameter int N  = 6,
    parameter int DW = 32,
    parameter int SW = 4,
    parameter int CW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [1:0]           sel_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [N-1:0]         hit_i,
    input  logic [N-1:0]         lvl_i,
    output logic [DW-1:0]        rdata_o,
    output logic [N-1:0][CW-1:0] mode_o,
    output logic [N-1:0]         pend_o,
    output logic [N-1:0]         en_o
);

    function automatic logic [DW-1:0] cfg_mask_f();
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < N; i++) m[i*SW +: CW] = '1;
        return m;
    endfunction

    localparam logic [DW-1:0] CFG_MASK = cfg_mask_f();

    typedef struct packed {
        logic [N-1:0][CW-1:0] cfg;
        logic [N-1:0]         pend;
        logic [N-1:0]         en;
    } regs_t;

    regs_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^(wdata_i & ~CFG_MASK);

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (sel_i)
                SEL_CFG: begin
                    for (int i = 0; i < N; i++) st_d.cfg[i] = wdata_i[i*SW +: CW];
                end
                SEL_PEND: st_d.pend = st_q.pend & wdata_i[N-1:0];
                SEL_EN:   st_d.en   = wdata_i[N-1:0];
                default:  ;
            endcase
        end
        // A detection in the same cycle overrides a clear
        st_d.pend = st_d.pend | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_CFG: begin
                for (int i = 0; i < N; i++) rdata_o[i*SW +: CW] = st_q.cfg[i];
            end
            SEL_LVL:  rdata_o[N-1:0] = lvl_i;
            SEL_PEND: rdata_o[N-1:0] = st_q.pend;
            SEL_EN:   rdata_o[N-1:0] = st_q.en;
            default:  ;
        endcase
    end

    assign mode_o = st_q.cfg;
    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R4 (also R3, R5): a flag only rises after its detector fired
        a_r4_set_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.pend[g]) |-> $past(hit_i[g]));
        // R6: a flag only falls after a pending write carrying 0 in its bit
        a_r6_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.pend[g]) |-> $past(wr_i && sel_i == SEL_PEND && !wdata_i[g]));
    end

    // R8: enables change only on an enable write
    a_r8_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_i && sel_i == SEL_EN) |-> $stable(st_q.en));

endmodule

// File: rtl/xirq_trigger_top.sv
`timescale 1ns/1ps
module xirq_trigger_top
    import xtu_pkg::*;
#(
    parameter int N_PINS = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int SLOT_W = 4,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [N_PINS-1:0] irq_o
);

    logic [N_PINS-1:0]             cur_w, prev_w, hit_w, pend_w, en_w;
    logic [N_PINS-1:0][CODE_W-1:0] mode_w;
    logic [DATA_W-1:0]             rd_w;
    logic                          aligned_w;

    assign aligned_w = (bus_addr_i[1:0] == 2'b00);

    xtu_sync #(.W(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pins_i),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    xtu_detect #(.N(N_PINS), .CW(CODE_W)) u_detect (
        .mode_i (mode_w),
        .cur_i  (cur_w),
        .prev_i (prev_w),
        .hit_o  (hit_w)
    );

    xtu_regs #(.N(N_PINS), .DW(DATA_W), .SW(SLOT_W), .CW(CODE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i & aligned_w),
        .sel_i   (bus_addr_i[3:2]),
        .wdata_i (bus_wdata_i),
        .hit_i   (hit_w),
        .lvl_i   (cur_w),
        .rdata_o (rd_w),
        .mode_o  (mode_w),
        .pend_o  (pend_w),
        .en_o    (en_w)
    );

    assign bus_rdata_o = aligned_w ? rd_w : '0;
    assign irq_o       = pend_w & en_w;

    // R12: a misaligned write leaves the enables untouched
    a_r12_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !aligned_w) |=> $stable(en_w));

endmodule

// File: tb/tb_xirq_trigger_top.sv
`timescale 1ns/1ps
module tb_xirq_trigger_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pins = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xirq_trigger_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // {pin[2:0], code[2:0], level_before, level_after, expected_pending}
    localparam int NV = 18;
    localparam logic [8:0] VEC [0:NV-1] = '{
        9'b000_001_0_1_1, 9'b001_001_1_0_0, 9'b010_010_1_0_1,
        9'b011_010_0_1_0, 9'b100_011_0_1_1, 9'b101_011_1_0_1,
        9'b000_011_1_1_0, 9'b001_101_0_1_1, 9'b010_101_0_0_0,
        9'b011_101_1_0_1, 9'b100_110_1_0_1, 9'b101_110_1_1_0,
        9'b000_110_0_1_1, 9'b001_000_0_1_0, 9'b010_100_0_1_0,
        9'b011_100_1_0_0, 9'b100_111_0_1_0, 9'b101_111_1_0_0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic string tag_of(input logic [2:0] m);
        if (m == 3'd0 || m == 3'd4 || m == 3'd7) return "R3";
        if (m <= 3'd3) return "R4";
        return "R5";
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(3);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), d);
            check(a == 4 ? "R10/R11" : "R10", d, 32'h0);
        end
        check("R10", {26'h0, irq}, 32'h0);

        // R2: reserved configuration bits
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); check("R2", d, 32'h0077_7777);
        wr(4'h0, 32'h0);

        // R11: level register shows synchronised pins, write ignored
        @(negedge clk) pins = 6'b101010;
        idle(4);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d); check("R11", d, 32'h2A);
        rd(4'h8, d); check("R11", d, 32'h0);
        @(negedge clk) pins = '0;
        idle(4);

        // R12: misaligned access ignored and reads zero
        wr(4'hD, 32'h3F);
        rd(4'hC, d); check("R12", d, 32'h0);
        rd(4'hD, d); check("R12", d, 32'h0);

        // Table walk: R3/R4/R5 and R9
        wr(4'hC, 32'h3F);
        for (int v = 0; v < NV; v++) begin
            logic [2:0] p, m;
            logic       l0, l1, e;
            {p, m, l0, l1, e} = VEC[v];
            wr(4'h0, 32'h0);
            @(negedge clk); pins = '0; pins[p] = l0;
            idle(4);
            wr(4'h8, 32'h0);
            wr(4'h0, 32'(m) << (4 * p));
            idle(4);
            @(negedge clk) pins[p] = l1;
            idle(5);
            rd(4'h8, d);
            check(tag_of(m), d, 32'(e) << p);
            check("R9", {26'h0, irq}, 32'(e) << p);
        end
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h0);
        @(negedge clk) pins = '0;
        idle(4);
        wr(4'h8, 32'h0);

        // R1: latency through the synchroniser (pin 0, rising edge)
        wr(4'h0, 32'h1);
        @(negedge clk) pins[0] = 1'b1;
        @(posedge clk); #1 bus_addr = 4'h4;
        #0.5 check("R1", {31'h0, bus_rdata[0]}, 32'h0);
        @(posedge clk); #1 bus_addr = 4'h4;
        #0.5 check("R1", {31'h0, bus_rdata[0]}, 32'h1);
        bus_addr = 4'h8;
        #0.5 check("R1", {31'h0, bus_rdata[0]}, 32'h0);
        @(posedge clk); #1 bus_addr = 4'h8;
        #0.5 check("R1", {31'h0, bus_rdata[0]}, 32'h1);

        // R7 and R6: flag held, write 1 keeps, write 0 clears
        idle(6);
        rd(4'h8, d); check("R7", d, 32'h1);
        wr(4'h8, 32'h3F);
        rd(4'h8, d); check("R6", d, 32'h1);
        wr(4'h8, 32'h3E);
        rd(4'h8, d); check("R6", d, 32'h0);

        // R6: detection wins over a clear (pin 1 high level, pin held high)
        wr(4'h0, 32'h50);
        @(negedge clk) pins[1] = 1'b1;
        idle(4);
        wr(4'h8, 32'h0);
        rd(4'h8, d); check("R6", d, 32'h2);

        // R8 and R9: enable readback and request gating
        wr(4'hC, 32'hFFFF_FFC0);
        rd(4'hC, d); check("R8", d, 32'h0);
        check("R9", {26'h0, irq}, 32'h0);
        wr(4'hC, 32'h0000_0002);
        check("R9", {26'h0, irq}, 32'h2);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, d); check("R8", d, 32'h3F);

        // R10: reset during operation
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) pins = '0;
        for (int a = 0; a < 16; a += 8) begin
            rd(4'(a), d); check("R10", d, 32'h0);
        end
        rd(4'hC, d); check("R10", d, 32'h0);
        check("R10", {26'h0, irq}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule